// File: doc/BRIEF.md
# Step-Locked Shadow Register File

This block is a general-purpose register file with a hidden twin, meant for a processor array that can run either as one wide thread or as two half-width threads. In single-thread mode the twin (the shadow copy) follows the main (primary) copy write for write, so the two always hold the same values. Only thread 0 is served, and it reads from the primary copy.

When the mode input asks for dual-thread operation, the block splits on the next clock edge. Thread 0 keeps the primary copy and thread 1 takes over the shadow copy. From then on each thread reads and writes its own copy and never sees the other's writes. When the mode input returns to single-thread, the shadow copy is hidden again. Neither transition copies any register contents: threads that need to share values do so through shared data memory, outside this block.

Each thread has two combinational read ports and one synchronous write port. Reads see the contents as they stood before the current edge, so a read of a register being written in the same cycle returns the old value.

Top module: `twin_regfile`

## Requirements
- R1: A synchronous active-low reset clears every register of both copies to zero and sets the mode to single-thread.
- R2: In single-thread mode, a thread 0 write stores its data at its address in both the primary and the shadow copy.
- R3: In single-thread mode, thread 0 reads come from the primary copy. Both thread 1 read outputs are zero, and thread 1 writes change neither copy.
- R4: In dual-thread mode, a thread 0 write changes only the primary copy and a thread 1 write changes only the shadow copy, even when both target the same address in the same cycle.
- R5: In dual-thread mode, both thread 1 read ports return shadow-copy contents.
- R6: Reads are combinational and read-before-write: in the cycle a register is written, a read of it returns the old value, and the new value appears after the clock edge.
- R7: The mode input (1 = dual-thread, 0 = single-thread) is sampled on the clock edge. A write presented in the same cycle as a mode change follows the mode that held before that edge.
- R8: Register contents of both copies are kept unchanged across split and unify. On a later split, thread 1 sees the shadow values left from earlier dual-thread writes and single-thread mirrored writes.
- R9: The two read ports of a thread are independent and may read different addresses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dual_mode_i | input | 1 | Requested mode: 1 = dual-thread, 0 = single-thread |
| t0_rd_addr_a | input | ADDR_W | Thread 0 read port A address |
| t0_rd_addr_b | input | ADDR_W | Thread 0 read port B address |
| t0_rd_data_a | output | DATA_W | Thread 0 read port A data (primary copy) |
| t0_rd_data_b | output | DATA_W | Thread 0 read port B data (primary copy) |
| t0_wr_en | input | 1 | Thread 0 write enable |
| t0_wr_addr | input | ADDR_W | Thread 0 write address |
| t0_wr_data | input | DATA_W | Thread 0 write data |
| t1_rd_addr_a | input | ADDR_W | Thread 1 read port A address |
| t1_rd_addr_b | input | ADDR_W | Thread 1 read port B address |
| t1_rd_data_a | output | DATA_W | Thread 1 read port A data (shadow copy, zero in single mode) |
| t1_rd_data_b | output | DATA_W | Thread 1 read port B data (shadow copy, zero in single mode) |
| t1_wr_en | input | 1 | Thread 1 write enable (dual mode only) |
| t1_wr_addr | input | ADDR_W | Thread 1 write address |
| t1_wr_data | input | DATA_W | Thread 1 write data |

## Verification
On every cycle the assertions check four things: the mode register follows the sampled mode input with one edge of delay, single-thread writes reach the shadow copy, dual-thread shadow writes come only from thread 1, and the hidden thread 1 outputs stay zero. They also check that a write becomes visible on the next cycle's read port for each thread. The bench scenarios cover what needs a history of stimulus. These are reset clearing, writes that coincide with a mode change, isolation when both threads write the same address, and contents that survive unify and reappear on a later split. A reference model of both copies, driven with random traffic, covers the combinations in between.

// File: rtl/twin_rf_pkg.sv
// Package: shared types for the step-locked shadow register file.
// Assumes nothing beyond being compiled before the modules that import it.
package twin_rf_pkg;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DUAL   = 1'b1
    } rf_mode_e;

endpackage

// File: rtl/twin_rf_bank.sv
// Module: one copy of the register file (a bank of NREGS words).
// Two combinational read ports, one synchronous write port, synchronous
// active-low clear. Assumes NREGS is a power of two so every address
// decodes to a word.
module twin_rf_bank #(
    parameter int NREGS  = 16,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] word [NREGS];

    for (genvar r = 0; r < NREGS; r++) begin : g_word
        logic [DATA_W-1:0] q;

        // Storage of one word: cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (waddr == ADDR_W'(r))) begin
                q <= wdata;
            end
        end

        assign word[r] = q;
    end

    // Read ports see pre-edge contents (read-before-write).
    assign rdata_a = word[raddr_a];
    assign rdata_b = word[raddr_b];

endmodule

// File: rtl/twin_rf_wsteer.sv
// Module: write steering between the primary and shadow banks.
// Single mode: thread 0 writes both banks, thread 1 is dropped.
// Dual mode: thread 0 writes the primary bank, thread 1 the shadow bank.
// Assumes mode is the registered (edge-sampled) mode.
module twin_rf_wsteer
    import twin_rf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  rf_mode_e          mode,
    input  logic              t0_we,
    input  logic [ADDR_W-1:0] t0_waddr,
    input  logic [DATA_W-1:0] t0_wdata,
    input  logic              t1_we,
    input  logic [ADDR_W-1:0] t1_waddr,
    input  logic [DATA_W-1:0] t1_wdata,
    output logic              prim_we,
    output logic [ADDR_W-1:0] prim_waddr,
    output logic [DATA_W-1:0] prim_wdata,
    output logic              shad_we,
    output logic [ADDR_W-1:0] shad_waddr,
    output logic [DATA_W-1:0] shad_wdata
);

    // Primary bank always belongs to thread 0.
    always_comb begin
        prim_we    = t0_we;
        prim_waddr = t0_waddr;
        prim_wdata = t0_wdata;
    end

    // Shadow bank mirrors thread 0 in single mode, belongs to thread 1 in dual.
    always_comb begin
        if (mode == MODE_DUAL) begin
            shad_we    = t1_we;
            shad_waddr = t1_waddr;
            shad_wdata = t1_wdata;
        end else begin
            shad_we    = t0_we;
            shad_waddr = t0_waddr;
            shad_wdata = t0_wdata;
        end
    end

endmodule

// File: rtl/twin_regfile.sv
// Module: step-locked shadow register file (top).
// Holds a primary and a shadow bank. The mode input is sampled on the clock
// edge; writes and reads in a cycle follow the mode held before that edge.
// Assumes the mode controller and any inter-thread data exchange are outside.
module twin_regfile
    import twin_rf_pkg::*;
#(
    parameter int NREGS  = 16,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_mode_i,
    input  logic [ADDR_W-1:0] t0_rd_addr_a,
    input  logic [ADDR_W-1:0] t0_rd_addr_b,
    output logic [DATA_W-1:0] t0_rd_data_a,
    output logic [DATA_W-1:0] t0_rd_data_b,
    input  logic              t0_wr_en,
    input  logic [ADDR_W-1:0] t0_wr_addr,
    input  logic [DATA_W-1:0] t0_wr_data,
    input  logic [ADDR_W-1:0] t1_rd_addr_a,
    input  logic [ADDR_W-1:0] t1_rd_addr_b,
    output logic [DATA_W-1:0] t1_rd_data_a,
    output logic [DATA_W-1:0] t1_rd_data_b,
    input  logic              t1_wr_en,
    input  logic [ADDR_W-1:0] t1_wr_addr,
    input  logic [DATA_W-1:0] t1_wr_data
);

    rf_mode_e          mode_q;
    logic              prim_we, shad_we;
    logic [ADDR_W-1:0] prim_waddr, shad_waddr;
    logic [DATA_W-1:0] prim_wdata, shad_wdata;
    logic [DATA_W-1:0] shad_rdata_a, shad_rdata_b;

    // Mode register: takes the requested mode on each edge, single on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SINGLE;
        end else begin
            mode_q <= dual_mode_i ? MODE_DUAL : MODE_SINGLE;
        end
    end

    twin_rf_wsteer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_wsteer (
        .mode       (mode_q),
        .t0_we      (t0_wr_en),
        .t0_waddr   (t0_wr_addr),
        .t0_wdata   (t0_wr_data),
        .t1_we      (t1_wr_en),
        .t1_waddr   (t1_wr_addr),
        .t1_wdata   (t1_wr_data),
        .prim_we    (prim_we),
        .prim_waddr (prim_waddr),
        .prim_wdata (prim_wdata),
        .shad_we    (shad_we),
        .shad_waddr (shad_waddr),
        .shad_wdata (shad_wdata)
    );

    twin_rf_bank #(
        .NREGS  (NREGS),
        .DATA_W (DATA_W)
    ) i_primary (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (prim_we),
        .waddr   (prim_waddr),
        .wdata   (prim_wdata),
        .raddr_a (t0_rd_addr_a),
        .raddr_b (t0_rd_addr_b),
        .rdata_a (t0_rd_data_a),
        .rdata_b (t0_rd_data_b)
    );

    twin_rf_bank #(
        .NREGS  (NREGS),
        .DATA_W (DATA_W)
    ) i_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (shad_we),
        .waddr   (shad_waddr),
        .wdata   (shad_wdata),
        .raddr_a (t1_rd_addr_a),
        .raddr_b (t1_rd_addr_b),
        .rdata_a (shad_rdata_a),
        .rdata_b (shad_rdata_b)
    );

    // Thread 1 read outputs: shadow contents in dual mode, hidden otherwise.
    always_comb begin
        if (mode_q == MODE_DUAL) begin
            t1_rd_data_a = shad_rdata_a;
            t1_rd_data_b = shad_rdata_b;
        end else begin
            t1_rd_data_a = '0;
            t1_rd_data_b = '0;
        end
    end

endmodule

// File: rtl/twin_regfile_chk.sv
// Module: assertion checker for twin_regfile, attached with bind below.
// Assumes it observes the top's ports plus the shadow write steering.
module twin_regfile_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dual_mode_i,
    input logic              mode_q,
    input logic              t0_wr_en,
    input logic [ADDR_W-1:0] t0_wr_addr,
    input logic [DATA_W-1:0] t0_wr_data,
    input logic [ADDR_W-1:0] t0_rd_addr_a,
    input logic [DATA_W-1:0] t0_rd_data_a,
    input logic              t1_wr_en,
    input logic [ADDR_W-1:0] t1_wr_addr,
    input logic [DATA_W-1:0] t1_wr_data,
    input logic [ADDR_W-1:0] t1_rd_addr_a,
    input logic [DATA_W-1:0] t1_rd_data_a,
    input logic [DATA_W-1:0] t1_rd_data_b,
    input logic              shad_we,
    input logic [ADDR_W-1:0] shad_waddr,
    input logic [DATA_W-1:0] shad_wdata
);

    // R7: the mode seen by the datapath is the mode input of the previous edge.
    p_mode_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mode_q == $past(dual_mode_i)));

    // R2: a single-mode thread 0 write reaches the shadow bank too.
    p_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && t0_wr_en) |->
            (shad_we && shad_waddr == t0_wr_addr && shad_wdata == t0_wr_data));

    // R3: thread 1 outputs are hidden in single mode.
    p_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (t1_rd_data_a == '0 && t1_rd_data_b == '0));

    // R4: in dual mode the shadow bank is written exactly when thread 1 writes.
    p_isolate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> ((shad_we == t1_wr_en) && (!t1_wr_en || shad_waddr == t1_wr_addr)));

    // R6: a thread 0 write is visible on the read port after the edge.
    p_t0_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        t0_wr_en |=> (!(t0_rd_addr_a == $past(t0_wr_addr)) ||
                      t0_rd_data_a == $past(t0_wr_data)));

    // R5: a dual-mode thread 1 write is visible to thread 1 after the edge.
    p_t1_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && t1_wr_en) |=> (!(mode_q && t1_rd_addr_a == $past(t1_wr_addr)) ||
                                  t1_rd_data_a == $past(t1_wr_data)));

endmodule

bind twin_regfile twin_regfile_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dual_mode_i  (dual_mode_i),
    .mode_q       (mode_q),
    .t0_wr_en     (t0_wr_en),
    .t0_wr_addr   (t0_wr_addr),
    .t0_wr_data   (t0_wr_data),
    .t0_rd_addr_a (t0_rd_addr_a),
    .t0_rd_data_a (t0_rd_data_a),
    .t1_wr_en     (t1_wr_en),
    .t1_wr_addr   (t1_wr_addr),
    .t1_wr_data   (t1_wr_data),
    .t1_rd_addr_a (t1_rd_addr_a),
    .t1_rd_data_a (t1_rd_data_a),
    .t1_rd_data_b (t1_rd_data_b),
    .shad_we      (shad_we),
    .shad_waddr   (shad_waddr),
    .shad_wdata   (shad_wdata)
);

// File: tb/test_twin_regfile.sv
// Bench for twin_regfile: a scoreboard of expected read values built from a
// reference model of both copies; a monitor compares them at the falling edge.
module test_twin_regfile;

    localparam int NREGS  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = $clog2(NREGS);

    typedef struct {
        int                th;
        int                port;
        logic [DATA_W-1:0] exp;
        string             tag;
    } sb_item_t;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              dual_mode_i;
    logic [ADDR_W-1:0] t0_rd_addr_a, t0_rd_addr_b, t0_wr_addr;
    logic [ADDR_W-1:0] t1_rd_addr_a, t1_rd_addr_b, t1_wr_addr;
    logic [DATA_W-1:0] t0_rd_data_a, t0_rd_data_b, t0_wr_data;
    logic [DATA_W-1:0] t1_rd_data_a, t1_rd_data_b, t1_wr_data;
    logic              t0_wr_en, t1_wr_en;

    logic [DATA_W-1:0] ref_p [NREGS];
    logic [DATA_W-1:0] ref_s [NREGS];
    logic              ref_mode;
    sb_item_t          sb [$];
    int                checks   = 0;
    int                failures = 0;
    bit                done     = 1'b0;

    // 125 MHz clock.
    always #4 clk = ~clk;

    twin_regfile #(.NREGS(NREGS), .DATA_W(DATA_W)) i_twin_regfile (
        .clk (clk), .rst_n (rst_n), .dual_mode_i (dual_mode_i),
        .t0_rd_addr_a (t0_rd_addr_a), .t0_rd_addr_b (t0_rd_addr_b),
        .t0_rd_data_a (t0_rd_data_a), .t0_rd_data_b (t0_rd_data_b),
        .t0_wr_en (t0_wr_en), .t0_wr_addr (t0_wr_addr), .t0_wr_data (t0_wr_data),
        .t1_rd_addr_a (t1_rd_addr_a), .t1_rd_addr_b (t1_rd_addr_b),
        .t1_rd_data_a (t1_rd_data_a), .t1_rd_data_b (t1_rd_data_b),
        .t1_wr_en (t1_wr_en), .t1_wr_addr (t1_wr_addr), .t1_wr_data (t1_wr_data)
    );

    // Monitor: pops every expected item queued this cycle and compares.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            sb_item_t it;
            logic [DATA_W-1:0] act;
            it = sb.pop_front();
            case ({it.th[0], it.port[0]})
                2'b00:   act = t0_rd_data_a;
                2'b01:   act = t0_rd_data_b;
                2'b10:   act = t1_rd_data_a;
                default: act = t1_rd_data_b;
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s: thread %0d port %0d actual=%h expected=%h",
                         it.tag, it.th, it.port, act, it.exp);
            end
        end
    end

    // Advance one edge; the model applies what the design sees at that edge.
    task automatic tick();
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                ref_p[i] = '0;
                ref_s[i] = '0;
            end
            ref_mode = 1'b0;
        end else begin
            if (t0_wr_en) begin
                ref_p[t0_wr_addr] = t0_wr_data;
                if (!ref_mode) ref_s[t0_wr_addr] = t0_wr_data;
            end
            if (t1_wr_en && ref_mode) ref_s[t1_wr_addr] = t1_wr_data;
            ref_mode = dual_mode_i;
        end
        @(posedge clk);
        #2;
    endtask

    // Driver: set a read address and queue the value the requirements predict.
    task automatic chk(int th, int port, int addr, string tag);
        sb_item_t it;
        logic [ADDR_W-1:0] a = ADDR_W'(addr);
        if (th == 0) begin
            if (port == 0) t0_rd_addr_a = a; else t0_rd_addr_b = a;
            it.exp = ref_p[a];
        end else begin
            if (port == 0) t1_rd_addr_a = a; else t1_rd_addr_b = a;
            it.exp = ref_mode ? ref_s[a] : '0;
        end
        it.th = th; it.port = port; it.tag = tag;
        sb.push_back(it);
    endtask

    // Explicit-value check, used where the bench states the number directly.
    task automatic chk_val(int th, int port, int addr, logic [DATA_W-1:0] v, string tag);
        sb_item_t it;
        logic [ADDR_W-1:0] a = ADDR_W'(addr);
        if (th == 0) begin
            if (port == 0) t0_rd_addr_a = a; else t0_rd_addr_b = a;
        end else begin
            if (port == 0) t1_rd_addr_a = a; else t1_rd_addr_b = a;
        end
        it.th = th; it.port = port; it.exp = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(int th, int addr, logic [DATA_W-1:0] v);
        if (th == 0) begin
            t0_wr_en = 1'b1; t0_wr_addr = ADDR_W'(addr); t0_wr_data = v;
        end else begin
            t1_wr_en = 1'b1; t1_wr_addr = ADDR_W'(addr); t1_wr_data = v;
        end
    endtask

    task automatic idle();
        t0_wr_en = 1'b0;
        t1_wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dual_mode_i = 1'b1; ref_mode = 1'b0;
        t0_rd_addr_a = '0; t0_rd_addr_b = '0; t1_rd_addr_a = '0; t1_rd_addr_b = '0;
        t0_wr_addr = '0; t0_wr_data = '0; t1_wr_addr = '0; t1_wr_data = '0;
        idle();
        for (int i = 0; i < NREGS; i++) begin ref_p[i] = 'x; ref_s[i] = 'x; end
        #2;
        // Fill both copies with writes during reset; reset must win.
        wr(0, 5, 32'hDEAD_BEEF);
        repeat (3) tick();
        rst_n = 1'b0; idle();
        tick();
        rst_n = 1'b1; dual_mode_i = 1'b0;
        // R1: cleared after reset, mode single (thread 1 hidden).
        chk_val(0, 0, 5, '0, "R1 primary cleared");
        chk_val(0, 1, 0, '0, "R1 primary word 0 cleared");
        chk_val(1, 0, 5, '0, "R1 thread 1 hidden after reset");
        tick();

        // R2/R3: single-mode write; thread 1 write in the same cycle is dropped.
        wr(0, 3, 32'hA000_0003);
        wr(1, 3, 32'hB000_0003);
        wr(1, 4, 32'hB000_0004);
        t1_wr_en = 1'b1;
        tick();
        idle();
        chk_val(0, 0, 3, 32'hA000_0003, "R2 thread 0 write lands");
        chk_val(0, 1, 4, '0, "R3 thread 1 write ignored in single mode");
        chk_val(1, 0, 3, '0, "R3 thread 1 port A reads zero");
        chk_val(1, 1, 4, '0, "R3 thread 1 port B reads zero");
        tick();

        // R6: read-before-write on the same register.
        wr(0, 3, 32'hC000_0003);
        chk_val(0, 0, 3, 32'hA000_0003, "R6 old value in write cycle");
        tick();
        idle();
        chk_val(0, 0, 3, 32'hC000_0003, "R6 new value after edge");
        tick();

        // Populate a pattern in single mode.
        for (int i = 8; i < NREGS; i++) begin
            wr(0, i, 32'h5000_0000 + DATA_W'(i));
            tick();
        end
        idle();

        // R7: split requested with a write in the same cycle: it is mirrored.
        dual_mode_i = 1'b1;
        wr(0, 7, 32'hD000_0007);
        chk(1, 0, 7, "R7 still single in split cycle");
        tick();
        idle();
        chk_val(1, 0, 7, 32'hD000_0007, "R7 split-cycle write mirrored");
        chk_val(1, 1, 3, 32'hC000_0003, "R2 earlier write mirrored");
        chk_val(0, 0, 7, 32'hD000_0007, "R7 primary has split-cycle write");
        tick();

        // R4: both threads write the same address in dual mode.
        wr(0, 3, 32'hE000_0003);
        wr(1, 3, 32'hF000_0003);
        tick();
        idle();
        chk_val(0, 0, 3, 32'hE000_0003, "R4 primary holds thread 0 value");
        chk_val(1, 0, 3, 32'hF000_0003, "R4 shadow holds thread 1 value");
        chk_val(0, 1, 9, 32'h5000_0009, "R9 thread 0 port B other address");
        chk_val(1, 1, 9, 32'h5000_0009, "R5 thread 1 port B reads shadow");
        tick();

        // R7: unify requested with a thread 1 write: it still goes to shadow.
        dual_mode_i = 1'b0;
        wr(1, 9, 32'h6000_0009);
        tick();
        idle();
        chk_val(0, 0, 9, 32'h5000_0009, "R8 primary untouched by thread 1");
        chk_val(1, 0, 9, '0, "R3 thread 1 hidden after unify");
        chk_val(0, 1, 3, 32'hE000_0003, "R8 primary kept at unify");
        tick();

        // R8: split again; shadow contents preserved, no copy made.
        dual_mode_i = 1'b1;
        tick();
        chk_val(1, 0, 9, 32'h6000_0009, "R8 unify-cycle write kept in shadow");
        chk_val(1, 1, 3, 32'hF000_0003, "R8 thread 1 value kept across unify");
        chk_val(0, 0, 3, 32'hE000_0003, "R8 primary not overwritten at split");
        tick();

        // R9 and model-driven random traffic across all modes.
        for (int n = 0; n < 400; n++) begin
            dual_mode_i = $urandom_range(0, 7) != 0 ? ref_mode : ~ref_mode;
            t0_wr_en = 1'($urandom);
            t0_wr_addr = ADDR_W'($urandom);
            t0_wr_data = $urandom;
            t1_wr_en = 1'($urandom);
            t1_wr_addr = ADDR_W'($urandom);
            t1_wr_data = $urandom;
            chk(0, 0, int'($urandom_range(0, NREGS - 1)), "R9 random thread 0 A");
            chk(0, 1, int'($urandom_range(0, NREGS - 1)), "R9 random thread 0 B");
            chk(1, 0, int'($urandom_range(0, NREGS - 1)), "R5 random thread 1 A");
            chk(1, 1, int'($urandom_range(0, NREGS - 1)), "R5 random thread 1 B");
            tick();
        end
        idle();

        // R1: reset while in dual mode clears both copies and returns to single.
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1; dual_mode_i = 1'b1;
        chk_val(0, 0, 3, '0, "R1 primary cleared by later reset");
        chk_val(1, 0, 3, '0, "R1 thread 1 hidden after later reset");
        tick();
        chk_val(1, 0, 3, '0, "R1 shadow cleared by later reset");
        chk_val(1, 1, 9, '0, "R1 shadow word 9 cleared");
        tick();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule